// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is the master side of a single open-drain one-wire line. The host presents a control word with a write strobe. That word can request a bus reset with presence detection, or a data operation of 1 to 4 bytes. A data operation is a read, a write, or a write followed by a read. The controller builds every bit slot from a microsecond tick. The tick comes from a divider of `CLK_PER_US` clock cycles that restarts at the start of each slot. The line itself is modelled as a drive-low enable `line_drive_low`, and the bus level comes back on `line_in`.

Two speeds are offered, normal and overdrive. The read sample point can be moved later for long or slowly discharging lines. Presence detection can be skipped, in which case the reset still waits out its full recovery window. A reset asked for in the same write as an operation runs first, and the operation then follows on its own. A reset written while an operation is running cancels that operation. Status is given by level flags and by one-cycle pulses: one pulse when an operation ends and another when a reset ends.

Top module: `onewire_master`

## Requirements
- R1: After `rst_n` is released, the outputs `line_drive_low`, `busy`, `no_presence`, `op_done`, `rst_done` and `rst_pending` are all 0, `op_pending` is 0 and `rx_data` is 0.
- R2: A host write with `cfg_rst_req`=1 starts a bus reset. `rst_pending` reads 1 until the reset has finished and then clears by itself, in the same cycle as a one-cycle `rst_done` pulse. The reset drives the line low for 480 µs at normal speed and 48 µs at overdrive. The total reset window is 960 µs at normal speed and 96 µs at overdrive.
- R3: Without skip, the line is sampled 70 µs after release (8 µs at overdrive). `no_presence` becomes 1 if the line was high at that point and 0 if a device held it low.
- R4: With `cfg_skip_pres`=1, no presence sampling takes effect and `no_presence` keeps its previous value.
- R5: `cfg_op` is encoded 0=none, 1=read, 2=write, 3=write then read. A write with a non-zero code while idle starts at once. `op_pending` reads back the code until the operation ends, and then a single one-cycle `op_done` pulse is raised.
- R6: `cfg_size` values 0,1,2,3 select 1,2,3,4 bytes. An operation uses 8 slots per byte for each of its write and read phases, so a write then read uses twice that number.
- R7: Write data is taken from `tx_data` at the request. Bits go out least significant first, lowest byte first. A 1 is a short low (6 µs normal, 1 µs overdrive) and a 0 is a long low (60 µs normal, 8 µs overdrive), in a 70 µs or 10 µs slot.
- R8: Read bits are placed in `rx_data` least significant first, lowest byte first. `rx_data` is cleared when any operation starts, so bytes that are not read, and all bytes after a write-only operation, read 0.
- R9: The read sample point is 16 µs after slot start at normal speed and 2 µs at overdrive. With `cfg_late`=1 it is 50 µs and 7 µs instead.
- R10: A write with both `cfg_rst_req`=1 and a non-zero `cfg_op` runs the reset first. The operation then starts by itself, and `rst_done` comes before `op_done`.
- R11: A reset request during an operation cancels it. `op_pending` takes the code written with the reset, which is 0 for a plain reset. No `op_done` is raised for the cancelled operation, its remaining slots are not run, and the reset starts.
- R12: `busy` is 1 while a reset or an operation is pending or running and 0 when the bus is idle. The line is never driven while `busy` is 0.
- R13: A write with `cfg_rst_req`=0 and a non-zero `cfg_op` while `busy`=1 is ignored. The running operation keeps its code and size, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_rst_req | input | 1 | Request a bus reset |
| cfg_op | input | 2 | Operation code: 0 none, 1 read, 2 write, 3 write then read |
| cfg_size | input | SIZE_W | Byte count minus one |
| cfg_overdrive | input | 1 | 1 selects overdrive timing |
| cfg_late | input | 1 | 1 moves the read sample point later |
| cfg_skip_pres | input | 1 | 1 skips presence sampling after a reset |
| tx_data | input | 8*2^SIZE_W | Transmit data, captured at the request |
| line_in | input | 1 | Sampled level of the bus line |
| line_drive_low | output | 1 | 1 pulls the open-drain line low |
| rx_data | output | 8*2^SIZE_W | Received data |
| busy | output | 1 | Reset or operation pending or running |
| no_presence | output | 1 | No presence pulse seen at the last sampled reset |
| op_done | output | 1 | One-cycle pulse when an operation completes |
| rst_done | output | 1 | One-cycle pulse when a reset completes |
| rst_pending | output | 1 | Reset request flag read-back |
| op_pending | output | 2 | Operation code read-back, 0 when none |

## Verification
The bench models a slave that decodes every master slot from the length of its low time and answers presence and read slots. Its read answers end between the early and the late sample points. A controller that samples at the wrong point therefore returns ordinary data in late mode, or all ones in early mode. The bench also goes after the ordering cases. It issues a reset together with an operation, which a broken design would run without the reset or never start. It cancels a long write part way through, where a broken design would resume it or still raise its done pulse. It issues a skipped-presence reset with no slave present, which a broken design would use to overwrite the presence flag. Finally it writes a new operation request while busy, which a broken design would accept, changing the slot count or adding a trailing operation.

// File: rtl/owm_pkg.sv
package owm_pkg;

   localparam int US_W = 10;
   localparam logic [US_W-1:0] US_ONE = US_W'(1);

   typedef enum logic [1:0] {
      SK_RESET = 2'd0,
      SK_W0    = 2'd1,
      SK_W1    = 2'd2,
      SK_READ  = 2'd3
   } slot_kind_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_WRRD  = 2'd3
   } op_e;

   typedef struct packed {
      logic [US_W-1:0] low;
      logic [US_W-1:0] samp;
      logic [US_W-1:0] len;
   } slot_tm_t;

   function automatic slot_tm_t mk_tm(input int l, input int s, input int n);
      slot_tm_t t;
      t.low  = US_W'(l);
      t.samp = US_W'(s);
      t.len  = US_W'(n);
      return t;
   endfunction

   // Low time, sample point and slot length, all in microseconds from slot start.
   function automatic slot_tm_t slot_timing(input slot_kind_e k, input logic od, input logic late);
      slot_tm_t t;
      unique case (k)
         SK_RESET: t = od ? mk_tm(48, 56, 96)  : mk_tm(480, 550, 960);
         SK_W0:    t = od ? mk_tm(8, 9, 10)    : mk_tm(60, 61, 70);
         SK_W1:    t = od ? mk_tm(1, 2, 10)    : mk_tm(6, 7, 70);
         default:  t = od ? mk_tm(1, late ? 7 : 2, 10)
                          : mk_tm(6, late ? 50 : 16, 70);
      endcase
      return t;
   endfunction

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
   parameter int DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad
         $error("owm_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = ~clr;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt <= '0;
            else if (clr || tick)             cnt <= '0;
            else                              cnt <= cnt + CW'(1);
         end
         assign tick = (cnt == CW'(DIV - 1)) && !clr;
      end
   endgenerate

endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("owm_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/owm_slot.sv
module owm_slot
   import owm_pkg::*;
#(
   parameter int CLK_PER_US = 125
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       abort,
   input  slot_kind_e kind,
   input  logic       od,
   input  logic       late,
   input  logic       line_s,
   output logic       active,
   output logic       drive_low,
   output logic       done,
   output logic       sample
);

   logic            tick;
   logic [US_W-1:0] cnt;
   slot_kind_e      kind_q;
   slot_tm_t        tm;
   logic            sample_now;

   owm_tick #(.DIV(CLK_PER_US)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start | abort),
      .tick (tick)
   );

   assign tm         = slot_timing(kind_q, od, late);
   assign drive_low  = active && (cnt < tm.low);
   assign sample_now = active && tick && (cnt == tm.samp - US_ONE);
   assign done       = active && tick && !abort && (cnt == tm.len - US_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         kind_q <= SK_RESET;
         sample <= 1'b1;
      end else if (abort) begin
         active <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= '0;
         kind_q <= kind;
      end else if (active && tick) begin
         if (sample_now) sample <= line_s;
         if (cnt == tm.len - US_ONE) active <= 1'b0;
         else                        cnt    <= cnt + US_ONE;
      end
   end

   // R9: the line is only sampled once the master has released it
   a_r9_sample_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      sample_now |-> !drive_low);

endmodule

// File: rtl/onewire_master.sv
module onewire_master
   import owm_pkg::*;
#(
   parameter int CLK_PER_US  = 125,
   parameter int SYNC_STAGES = 2,
   parameter int SIZE_W      = 2,
   localparam int MAX_BYTES  = 1 << SIZE_W,
   localparam int DATA_W     = 8 * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_rst_req,
   input  logic [1:0]        cfg_op,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic              cfg_overdrive,
   input  logic              cfg_late,
   input  logic              cfg_skip_pres,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              line_in,
   output logic              line_drive_low,
   output logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              no_presence,
   output logic              op_done,
   output logic              rst_done,
   output logic              rst_pending,
   output logic [1:0]        op_pending
);

   localparam int DW_W  = $clog2(DATA_W);
   localparam int IDX_W = $clog2(2 * DATA_W) + 1;

   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("onewire_master: CLK_PER_US must be at least 1");
      end
      if (SIZE_W < 1 || SIZE_W > 3) begin : g_bad_size
         $error("onewire_master: SIZE_W must be 1 to 3");
      end
   endgenerate

   logic              line_s;
   logic              rst_flag;
   op_e               op_reg;
   logic [SIZE_W-1:0] size_reg;
   logic [DATA_W-1:0] tx_lat;
   logic [DATA_W-1:0] rx_reg;
   logic [IDX_W-1:0]  idx;
   logic              launch;
   logic              nopres_q;
   logic              op_done_q;
   logic              rst_done_q;

   logic              host_rst;
   logic              host_op;
   logic [IDX_W-1:0]  nbits;
   logic [IDX_W-1:0]  total;
   logic              wr_phase;
   logic [DW_W-1:0]   rd_pos;
   slot_kind_e        kind;
   logic              slot_active;
   logic              slot_drive;
   logic              slot_done;
   logic              slot_sample;

   owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (line_in),
      .q    (line_s)
   );

   assign busy     = rst_flag || (op_reg != OP_NONE);
   assign host_rst = cfg_we && cfg_rst_req;
   assign host_op  = cfg_we && !cfg_rst_req && (cfg_op != 2'd0) && !busy;

   assign nbits    = IDX_W'((int'(size_reg) + 1) * 8);
   assign total    = (op_reg == OP_WRRD) ? (nbits << 1) : nbits;
   assign wr_phase = (op_reg == OP_WRITE) || ((op_reg == OP_WRRD) && (idx < nbits));
   assign rd_pos   = (op_reg == OP_WRRD) ? DW_W'(idx - nbits) : DW_W'(idx);

   always_comb begin
      if (rst_flag)      kind = SK_RESET;
      else if (wr_phase) kind = tx_lat[DW_W'(idx)] ? SK_W1 : SK_W0;
      else               kind = SK_READ;
   end

   owm_slot #(.CLK_PER_US(CLK_PER_US)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (launch),
      .abort    (host_rst),
      .kind     (kind),
      .od       (cfg_overdrive),
      .late     (cfg_late),
      .line_s   (line_s),
      .active   (slot_active),
      .drive_low(slot_drive),
      .done     (slot_done),
      .sample   (slot_sample)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_flag   <= 1'b0;
         op_reg     <= OP_NONE;
         size_reg   <= '0;
         tx_lat     <= '0;
         rx_reg     <= '0;
         idx        <= '0;
         launch     <= 1'b0;
         nopres_q   <= 1'b0;
         op_done_q  <= 1'b0;
         rst_done_q <= 1'b0;
      end else begin
         launch     <= 1'b0;
         op_done_q  <= 1'b0;
         rst_done_q <= 1'b0;
         if (host_rst) begin
            rst_flag <= 1'b1;
            op_reg   <= op_e'(cfg_op);
            size_reg <= cfg_size;
            tx_lat   <= tx_data;
            idx      <= '0;
            launch   <= 1'b1;
            if (cfg_op != 2'd0) rx_reg <= '0;
         end else if (host_op) begin
            op_reg   <= op_e'(cfg_op);
            size_reg <= cfg_size;
            tx_lat   <= tx_data;
            rx_reg   <= '0;
            idx      <= '0;
            launch   <= 1'b1;
         end else if (slot_done) begin
            if (rst_flag) begin
               rst_flag   <= 1'b0;
               rst_done_q <= 1'b1;
               if (!cfg_skip_pres)     nopres_q <= slot_sample;
               if (op_reg != OP_NONE)  launch   <= 1'b1;
            end else if (op_reg != OP_NONE) begin
               if (!wr_phase) rx_reg[rd_pos] <= slot_sample;
               if (idx == total - IDX_W'(1)) begin
                  op_reg    <= OP_NONE;
                  op_done_q <= 1'b1;
               end else begin
                  idx    <= idx + IDX_W'(1);
                  launch <= 1'b1;
               end
            end
         end
      end
   end

   assign line_drive_low = slot_drive;
   assign rx_data        = rx_reg;
   assign no_presence    = nopres_q;
   assign op_done        = op_done_q;
   assign rst_done       = rst_done_q;
   assign rst_pending    = rst_flag;
   assign op_pending     = op_reg;

   // R12: no drive while nothing is pending
   a_r12_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_drive_low);

   // R12: a slot is only launched with work pending
   a_r12_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> busy);

   // R5: the two completion pulses never coincide
   a_r5_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_done, rst_done}));

   // R5: operation code reads zero once done is flagged
   a_r5_done_clears_op: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |-> (op_pending == 2'd0));

   // R2: the reset flag is clear when its done pulse appears
   a_r2_rst_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rst_done |-> !rst_pending);

   // R11: a reset request never yields an operation done pulse next
   a_r11_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst |=> !op_done);

   // R13: an operation request while busy leaves the code alone
   a_r13_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_rst_req && (cfg_op != 2'd0) && busy)
      |=> ((op_pending == $past(op_pending)) || op_done));

endmodule

// File: tb/onewire_master_tb.sv
`timescale 1ns/1ps
module onewire_master_tb;

   localparam int CPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_rst_req = 1'b0;
   logic [1:0]  cfg_op = 2'd0, cfg_size = 2'd0;
   logic        cfg_od = 1'b0, cfg_late = 1'b0, cfg_skip = 1'b0;
   logic [31:0] tx_data = 32'd0;
   logic        line_r = 1'b1;

   logic        drv, busy, nopres, op_done, rst_done, rst_pending;
   logic [31:0] rx_data;
   logic [1:0]  op_pending;

   always #4 clk = ~clk;

   onewire_master #(.CLK_PER_US(CPU)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rst_req(cfg_rst_req),
      .cfg_op(cfg_op), .cfg_size(cfg_size), .cfg_overdrive(cfg_od),
      .cfg_late(cfg_late), .cfg_skip_pres(cfg_skip), .tx_data(tx_data),
      .line_in(line_r), .line_drive_low(drv), .rx_data(rx_data), .busy(busy),
      .no_presence(nopres), .op_done(op_done), .rst_done(rst_done),
      .rst_pending(rst_pending), .op_pending(op_pending));

   int tests = 0, fails = 0, cyc = 0;
   int low_cnt = 0, last_reset_low = 0, hold = 0, pres_delay = 0, pres_left = 0;
   int s_idx = 0, wr_bits = 0, nreset = 0;
   int op_cnt = 0, rst_cnt = 0, dbl = 0, cyc_rst = 0, cyc_op = 0;
   logic        drv_prev = 1'b0, op_prev = 1'b0, rs_prev = 1'b0;
   logic [63:0] cap = '0;
   logic [31:0] rd_pat = '0;
   logic        rd_active = 1'b0, present = 1'b0;
   logic        done_flag = 1'b0;

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 195000) begin
         tests++; fails++;
         $display("FAIL watchdog: run did not finish, act=%0d exp<195000", cyc);
         summary();
      end
   end

   // Slave model and pulse monitor, evaluated away from the active edge
   always @(negedge clk) begin
      if (drv && !drv_prev) begin
         low_cnt = 1;
         if (rd_active && s_idx >= wr_bits && (s_idx - wr_bits) < 32 && !rd_pat[s_idx - wr_bits])
            hold = (cfg_od ? 4 : 25) * CPU;
      end else if (drv) low_cnt++;
      if (!drv && drv_prev) begin
         if (low_cnt > (cfg_od ? 30 : 300) * CPU) begin
            nreset++;
            last_reset_low = low_cnt;
            if (present) begin
               pres_delay = 2 * CPU;
               pres_left  = (cfg_od ? 16 : 120) * CPU;
            end
         end else begin
            if (s_idx < 64) cap[s_idx] = (low_cnt < (cfg_od ? 4 : 30) * CPU);
            s_idx++;
         end
      end
      drv_prev = drv;
      if (hold > 0) hold--;
      if (pres_delay > 0) pres_delay--;
      else if (pres_left > 0) pres_left--;
      line_r = !(drv || hold > 0 || (pres_delay == 0 && pres_left > 0));
      if (op_done) begin
         op_cnt++; cyc_op = cyc;
         if (op_prev) dbl++;
      end
      if (rst_done) begin
         rst_cnt++; cyc_rst = cyc;
         if (rs_prev) dbl++;
      end
      op_prev = op_done;
      rs_prev = rst_done;
   end

   task automatic check(input logic ok, input string what, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] mask_of(input logic [1:0] sz);
      case (sz)
         2'd0: return 32'h0000_00FF;
         2'd1: return 32'h0000_FFFF;
         2'd2: return 32'h00FF_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [31:0] exp_rx(input logic [1:0] op, input logic [1:0] sz,
                                          input logic [31:0] pat, input logic late);
      if (!op[0]) return 32'd0;
      return late ? mask_of(sz) : (pat & mask_of(sz));
   endfunction

   function automatic logic [31:0] cap_word(input int nb);
      logic [31:0] w = '0;
      for (int i = 0; i < nb; i++) w[i] = cap[i];
      return w;
   endfunction

   task automatic host_write(input logic r, input logic [1:0] op, input logic [1:0] sz);
      @(negedge clk);
      cfg_we = 1'b1; cfg_rst_req = r; cfg_op = op; cfg_size = sz;
      @(negedge clk);
      cfg_we = 1'b0; cfg_rst_req = 1'b0; cfg_op = 2'd0;
   endtask

   task automatic wait_op(input int n0);
      int t = 0;
      while (op_cnt == n0 && t < 40000) begin @(negedge clk); t++; end
   endtask

   task automatic wait_rst(input int n0);
      int t = 0;
      while (rst_cnt == n0 && t < 10000) begin @(negedge clk); t++; end
   endtask

   task automatic bus_reset(input logic pres, input logic skip, input string tag);
      int n0 = rst_cnt;
      present = pres; cfg_skip = skip; rd_active = 1'b0;
      host_write(1'b1, 2'd0, 2'd0);
      repeat (10) @(negedge clk);
      check(rst_pending == 1'b1, {tag, " R2 reset flag held"}, rst_pending, 1);
      check(busy == 1'b1, {tag, " R12 busy during reset"}, busy, 1);
      wait_rst(n0);
      check(rst_cnt == n0 + 1, {tag, " R2 rst_done pulse"}, rst_cnt, n0 + 1);
      check(rst_pending == 1'b0, {tag, " R2 reset flag cleared"}, rst_pending, 0);
      @(negedge clk);
      check(busy == 1'b0, {tag, " R12 idle after reset"}, busy, 0);
      cfg_skip = 1'b0;
   endtask

   task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] tx,
                         input logic [31:0] pat, input logic late, input string tag);
      int nb = 8 * (int'(sz) + 1);
      int tot = (op == 2'd3) ? 2 * nb : nb;
      int n0 = op_cnt;
      wr_bits = (op == 2'd3) ? nb : 0;
      rd_active = op[0]; rd_pat = pat; s_idx = 0; cap = '0;
      tx_data = tx; cfg_late = late;
      host_write(1'b0, op, sz);
      repeat (3) @(negedge clk);
      check(op_pending == op, {tag, " R5 op code read back"}, op_pending, op);
      check(busy == 1'b1, {tag, " R12 busy during op"}, busy, 1);
      wait_op(n0);
      check(op_cnt == n0 + 1, {tag, " R5 op_done pulse"}, op_cnt, n0 + 1);
      check(op_pending == 2'd0 && busy == 1'b0, {tag, " R5 R12 idle after op"}, {op_pending, busy}, 0);
      check(s_idx == tot, {tag, " R6 slot count"}, s_idx, tot);
      if (op[1]) check(cap_word(nb) == (tx & mask_of(sz)), {tag, " R7 written bits"},
                       cap_word(nb), tx & mask_of(sz));
      check(rx_data == exp_rx(op, sz, pat, late), {tag, " R8 R9 received data"},
            rx_data, exp_rx(op, sz, pat, late));
   endtask

   initial begin
      int n_op, n_rs, n_rc, keep;
      logic [31:0] r;
      r = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({drv, busy, nopres, op_done, rst_done, rst_pending} == 6'b0, "R1 idle outputs",
            {drv, busy, nopres, op_done, rst_done, rst_pending}, 0);
      check(op_pending == 2'd0 && rx_data == 32'd0, "R1 op code and rx clear", rx_data, 0);

      // R2 R3 normal reset, slave present then absent
      cfg_od = 1'b0;
      bus_reset(1'b1, 1'b0, "norm present");
      check(last_reset_low >= 480*CPU - 1 && last_reset_low <= 480*CPU + 1,
            "R2 normal reset low time", last_reset_low, 480*CPU);
      check(nopres == 1'b0, "R3 presence seen", nopres, 0);
      bus_reset(1'b0, 1'b0, "norm absent");
      check(nopres == 1'b1, "R3 no presence flagged", nopres, 1);

      // R2 R3 overdrive reset
      cfg_od = 1'b1;
      bus_reset(1'b1, 1'b0, "od present");
      check(last_reset_low >= 48*CPU - 1 && last_reset_low <= 48*CPU + 1,
            "R2 overdrive reset low time", last_reset_low, 48*CPU);
      check(nopres == 1'b0, "R3 overdrive presence seen", nopres, 0);

      // R4 skip with no slave keeps flag at 0
      bus_reset(1'b0, 1'b1, "od skip");
      check(nopres == 1'b0, "R4 skip leaves no_presence", nopres, 0);

      // R6 R7 R8 directed normal-speed cases
      cfg_od = 1'b0;
      run_op(2'd2, 2'd3, 32'hA5C3_0F81, 32'd0, 1'b0, "norm write4");
      run_op(2'd1, 2'd0, 32'd0, 32'h0000_005A, 1'b0, "norm read1 early");
      run_op(2'd1, 2'd0, 32'd0, 32'h0000_005A, 1'b1, "norm read1 late R9");
      cfg_od = 1'b1;
      run_op(2'd1, 2'd1, 32'd0, 32'h0000_1234, 1'b0, "od read2 early R9");
      run_op(2'd1, 2'd1, 32'd0, 32'h0000_1234, 1'b1, "od read2 late R9");
      run_op(2'd3, 2'd2, 32'h00C0_FFEE, 32'h0036_9C5A, 1'b0, "od wrrd3");
      run_op(2'd2, 2'd0, 32'h0000_00E7, 32'd0, 1'b0, "od write clears rx R8");

      // R10 reset together with write then read
      cfg_od = 1'b0; present = 1'b1;
      n_op = op_cnt; n_rc = rst_cnt; n_rs = nreset;
      wr_bits = 16; rd_active = 1'b1; rd_pat = 32'h0000_0F0F; s_idx = 0; cap = '0;
      tx_data = 32'h0000_BEEF; cfg_late = 1'b0;
      host_write(1'b1, 2'd3, 2'd1);
      wait_op(n_op);
      check(rst_cnt == n_rc + 1 && nreset == n_rs + 1, "R10 reset ran", rst_cnt, n_rc + 1);
      check(op_cnt == n_op + 1, "R10 op followed", op_cnt, n_op + 1);
      check(cyc_rst < cyc_op, "R10 reset before op", cyc_rst, cyc_op);
      check(s_idx == 32 && cap_word(16) == 32'h0000_BEEF, "R10 op written bits",
            cap_word(16), 32'h0000_BEEF);
      check(rx_data == 32'h0000_0F0F && nopres == 1'b0, "R10 op read data", rx_data, 32'h0F0F);

      // R11 reset cancels a running write
      rd_active = 1'b0; s_idx = 0; tx_data = 32'h1234_5678;
      host_write(1'b0, 2'd2, 2'd3);
      repeat (1500) @(negedge clk);
      n_op = op_cnt; n_rc = rst_cnt; n_rs = nreset;
      host_write(1'b1, 2'd0, 2'd0);
      check(op_pending == 2'd0 && rst_pending == 1'b1, "R11 op cleared, reset pending",
            {op_pending, rst_pending}, 1);
      wait_rst(n_rc);
      keep = s_idx;
      repeat (500) @(negedge clk);
      check(op_cnt == n_op, "R11 no done for cancelled op", op_cnt, n_op);
      check(nreset == n_rs + 1, "R11 reset started", nreset, n_rs + 1);
      check(s_idx == keep && busy == 1'b0, "R11 R12 op not resumed", s_idx, keep);

      // R13 request while busy is ignored
      cfg_od = 1'b1; s_idx = 0; cap = '0; tx_data = 32'h0000_003C;
      n_op = op_cnt;
      host_write(1'b0, 2'd2, 2'd0);
      repeat (5) @(negedge clk);
      host_write(1'b0, 2'd1, 2'd3);
      check(op_pending == 2'd2, "R13 code kept", op_pending, 2);
      wait_op(n_op);
      repeat (300) @(negedge clk);
      check(s_idx == 8 && cap_word(8) == 32'h3C, "R13 size kept", s_idx, 8);
      check(op_cnt == n_op + 1 && busy == 1'b0, "R13 no second op", op_cnt, n_op + 1);

      // Constrained random operations
      for (int k = 0; k < 10; k++) begin
         logic [1:0] op, sz;
         logic late;
         op = 2'(1 + $urandom_range(0, 2));
         cfg_od = 1'($urandom_range(0, 1));
         sz = 2'(cfg_od ? $urandom_range(0, 3) : $urandom_range(0, 1));
         late = 1'($urandom_range(0, 1));
         run_op(op, sz, $urandom, $urandom, late, "random R5 R6 R7");
      end

      check(dbl == 0, "R5 R2 done pulses one cycle wide", dbl, 0);
      summary();
   end

endmodule